// File: doc/BRIEF.md
# Parallel Camera Capture Unit

This block takes a parallel pixel stream from an image sensor and delivers it as a byte stream with frame markers. The sensor drives a pixel clock, a frame sync, a line sync, a line-valid/data-enable strobe and an 8-bit or 16-bit sample bus. Samples are taken on the rising edge of the pixel clock after its optional inversion. Each qualified sample is optionally bit-reversed and byte-swapped. It then crosses into the system clock domain through a gray-pointer asynchronous FIFO. On the system side a consumer drains the FIFO with a valid/ready handshake, one byte per beat.

Capture locks onto the frame timing only after a programmable number of frame-sync pulses that are long enough to count. End-of-frame is flagged either after a programmed byte count or at the next frame-sync pulse. With auto-stop enabled, the unit clears its own run state once the FIFO has filled. This protects the stored data when the consumer stops draining. The unit can also drive a divided copy of the system clock to the sensor.

All configuration inputs are copied into shadow registers only on an update strobe. Software is expected to pulse the capture-state reset and the FIFO reset before each start.

Top module: `dvp_capture`

## Requirements
- R1: After reset, `running`, `out_valid` and `mclk_out` are low.
- R2: Configuration inputs take effect only on a cycle where `cfg_update` is high. Changing them without the strobe leaves capture unchanged.
- R3: A frame-sync pulse is valid only if the active level lasts at least 2 pixel clocks. When `cfg_vs_filt_en` is 1, lock needs `cfg_vs_thresh`+1 valid pulses (3-bit field, 1 to 8 pulses). When it is 0, lock happens on the first valid pulse and `cfg_vs_thresh` is ignored. Every sample before lock is discarded.
- R4: Samples qualify only while the frame sync is inactive. With `cfg_de_mode`=0, `hen_de` must also be active. With `cfg_de_mode`=1, `hen_de` must be active and `hsync` inactive.
- R5: Setting `cfg_inv_pclk` moves sampling to the falling pin edge. Setting `cfg_inv_vsync`, `cfg_inv_hsync` or `cfg_inv_de` makes the matching input active-low.
- R6: With `cfg_wide`=0, each sample yields one byte, `pix_data[7:0]`, and bits 15:8 are ignored. With `cfg_wide`=1, each sample yields two bytes: bits 7:0 first, then bits 15:8 of the transformed sample.
- R7: `cfg_bit_rev` reverses the bits across the active sample width (8 or 16 bits). After that, `cfg_byte_swap` (16-bit only) exchanges the two bytes.
- R8: With `cfg_eof_vsync`=0, `out_eof` marks the byte that brings the frame byte count to at least `cfg_rx_len`. The count then restarts.
- R9: With `cfg_eof_vsync`=1, the last sample before the next valid frame-sync pulse is held back. That sample is released with `out_eof` on its final byte.
- R10: With `cfg_stop_en`=1, `running` falls once the FIFO is full. The FIFO keeps exactly the first DEPTH samples written to it.
- R11: `start_set` sets `running` and `start_clr` clears it, with clear taking priority. While stopped, no samples are captured.
- R12: `fifo_reset` empties the FIFO, and `out_valid` is low on the next cycle. `ctl_reset` drops lock, so samples after it are discarded until a new valid frame-sync pulse.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eof` hold their values.
- R14: With `mclk_en`=1, `mclk_out` toggles every MCLK_HALF system clocks. With `mclk_en`=0, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_update | input | 1 | Copies all cfg_* inputs into shadow registers |
| cfg_wide | input | 1 | 1 = 16-bit sample bus |
| cfg_byte_swap | input | 1 | Swap bytes of 16-bit sample |
| cfg_bit_rev | input | 1 | Reverse bit order of sample |
| cfg_vs_filt_en | input | 1 | Enable multi-pulse lock filter |
| cfg_vs_thresh | input | 3 | Pulses needed minus one |
| cfg_eof_vsync | input | 1 | 1 = end-of-frame at frame sync, 0 = by byte count |
| cfg_de_mode | input | 1 | 1 = qualify with data-enable and line sync |
| cfg_inv_pclk | input | 1 | Invert pixel clock |
| cfg_inv_de | input | 1 | Invert line-valid/data-enable |
| cfg_inv_hsync | input | 1 | Invert line sync |
| cfg_inv_vsync | input | 1 | Invert frame sync |
| cfg_stop_en | input | 1 | Auto-stop on FIFO full |
| cfg_rx_len | input | LEN_W | Frame length in bytes for count mode |
| ctl_reset | input | 1 | Clears capture state (lock, counters) |
| fifo_reset | input | 1 | Clears the asynchronous FIFO |
| start_set | input | 1 | Start capture |
| start_clr | input | 1 | Stop capture |
| running | output | 1 | Run status |
| mclk_en | input | 1 | Enable sensor clock output |
| mclk_out | output | 1 | Divided clock to sensor |
| pclk | input | 1 | Pixel clock from sensor |
| vsync | input | 1 | Frame sync |
| hsync | input | 1 | Line sync |
| hen_de | input | 1 | Line-valid / data-enable |
| pix_data | input | 16 | Sample bus |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | Byte is last of frame |

## Verification
A lock counter that is off by one shows at the ports as a whole frame of bytes appearing, or missing, after the pulse sequence that should have locked. A wrong held-sample or byte-count state moves `out_eof` to a different byte within a few pixel clocks of the frame boundary. Pointer or full-flag errors in the FIFO show up as a captured count other than the depth once the consumer stalls, or as `running` failing to fall a few system cycles after the FIFO fills. Handshake or flush errors change `out_data` under stall, or leave `out_valid` high one cycle after a flush.

// File: rtl/dvp_cap_pkg.sv
package dvp_cap_pkg;
   localparam int SAMPLE_W = 16;

   typedef struct packed {
      logic       wide;
      logic       byte_swap;
      logic       bit_rev;
      logic       vs_filt_en;
      logic [2:0] vs_thresh;
      logic       eof_vsync;
      logic       de_mode;
      logic       inv_pclk;
      logic       inv_de;
      logic       inv_hsync;
      logic       inv_vsync;
      logic       stop_en;
   } cap_cfg_t;

   typedef struct packed {
      logic                eof;
      logic                two;
      logic [SAMPLE_W-1:0] data;
   } fifo_ent_t;
endpackage

// File: rtl/dvp_rst_sync.sv
module dvp_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   if (STAGES < 2) begin : g_bad
      $error("dvp_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh <= '0;
      else         sh <= {sh[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = sh[STAGES-1];
endmodule

// File: rtl/dvp_sync.sv
module dvp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("dvp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dvp_afifo.sv
module dvp_afifo #(
   parameter int DW     = 18,
   parameter int AW     = 4,
   parameter int STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic          wfull,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rd_en,
   output logic [DW-1:0] rdata,
   output logic          rempty,
   output logic          rfull
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] DEPTH_P = DEPTH[AW:0];

   if (AW < 2) begin : g_bad
      $error("dvp_afifo: AW must be at least 2");
   end

   function automatic logic [AW:0] to_gray(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wbin, wgray, rbin, rgray;
   logic [AW:0]   rgray_w, wgray_r;

   // write side
   always_ff @(posedge wclk) begin
      if (wr_en && !wfull) mem[wbin[AW-1:0]] <= wdata;
   end

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_en && !wfull) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end
   end

   dvp_sync #(.W(AW+1), .STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

   assign wfull = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});

   // read side
   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_en && !rempty) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end
   end

   dvp_sync #(.W(AW+1), .STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

   assign rempty = (rgray == wgray_r);
   assign rdata  = mem[rbin[AW-1:0]];
   assign rfull  = ((from_gray(wgray_r) - rbin) == DEPTH_P);
endmodule

// File: rtl/dvp_pix_front.sv
module dvp_pix_front
   import dvp_cap_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic                pclk,
   input  logic                prst_n,
   input  logic                run,
   input  cap_cfg_t            cfg,
   input  logic [LEN_W-1:0]    rx_len,
   input  logic                vsync,
   input  logic                hsync,
   input  logic                hen,
   input  logic [SAMPLE_W-1:0] data,
   output logic                wr_en,
   output fifo_ent_t           wdata
);
   localparam int HB = SAMPLE_W / 2;

   logic                vs_r, hs_r, de_r;
   logic [SAMPLE_W-1:0] d_r;
   logic [1:0]          vs_hi;
   logic [3:0]          pulses, need;
   logic                locked;
   logic [LEN_W:0]      bytecnt, cnt_next;
   logic                held_v;
   logic [SAMPLE_W-1:0] held;

   // input capture with polarity applied
   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         vs_r <= 1'b0;
         hs_r <= 1'b0;
         de_r <= 1'b0;
         d_r  <= '0;
      end else begin
         vs_r <= vsync ^ cfg.inv_vsync;
         hs_r <= hsync ^ cfg.inv_hsync;
         de_r <= hen ^ cfg.inv_de;
         d_r  <= data;
      end
   end

   // sample transform: width select, bit reversal, byte swap
   logic [SAMPLE_W-1:0] raw, rev_w, ord, fin;
   logic [HB-1:0]       rev_n;

   assign raw = cfg.wide ? d_r : {{HB{1'b0}}, d_r[HB-1:0]};

   for (genvar i = 0; i < SAMPLE_W; i++) begin : g_rev_w
      assign rev_w[i] = raw[SAMPLE_W-1-i];
   end
   for (genvar i = 0; i < HB; i++) begin : g_rev_n
      assign rev_n[i] = raw[HB-1-i];
   end

   always_comb begin
      if (!cfg.bit_rev)  ord = raw;
      else if (cfg.wide) ord = rev_w;
      else               ord = {{HB{1'b0}}, rev_n};
      fin = (cfg.wide && cfg.byte_swap) ? {ord[HB-1:0], ord[SAMPLE_W-1:HB]} : ord;
   end

   // frame-sync qualification and lock
   logic vs_pulse, qual, len_hit, vs_eof;

   assign vs_pulse = vs_r && (vs_hi == 2'd1);
   assign need     = cfg.vs_filt_en ? ({1'b0, cfg.vs_thresh} + 4'd1) : 4'd1;
   assign qual     = locked && !vs_r && (cfg.de_mode ? (de_r && !hs_r) : de_r);
   assign cnt_next = bytecnt + (cfg.wide ? 2 : 1);
   assign len_hit  = (cnt_next >= {1'b0, rx_len});
   assign vs_eof   = cfg.eof_vsync && vs_pulse && locked && held_v;

   always_comb begin
      wr_en = 1'b0;
      wdata = '0;
      if (run) begin
         if (vs_eof) begin
            wr_en = 1'b1;
            wdata = '{eof: 1'b1, two: cfg.wide, data: held};
         end else if (qual) begin
            if (!cfg.eof_vsync) begin
               wr_en = 1'b1;
               wdata = '{eof: len_hit, two: cfg.wide, data: fin};
            end else if (held_v) begin
               wr_en = 1'b1;
               wdata = '{eof: 1'b0, two: cfg.wide, data: held};
            end
         end
      end
   end

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         vs_hi   <= '0;
         pulses  <= '0;
         locked  <= 1'b0;
         bytecnt <= '0;
         held_v  <= 1'b0;
         held    <= '0;
      end else begin
         if (!vs_r)              vs_hi <= 2'd0;
         else if (vs_hi != 2'd2) vs_hi <= vs_hi + 2'd1;

         if (!run) begin
            pulses  <= '0;
            locked  <= 1'b0;
            bytecnt <= '0;
            held_v  <= 1'b0;
         end else begin
            if (vs_pulse && !locked) begin
               pulses <= pulses + 4'd1;
               if ((pulses + 4'd1) >= need) locked <= 1'b1;
            end
            if (vs_eof) held_v <= 1'b0;
            if (qual) begin
               if (cfg.eof_vsync) begin
                  held   <= fin;
                  held_v <= 1'b1;
               end else begin
                  bytecnt <= len_hit ? '0 : cnt_next;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dvp_unpack.sv
module dvp_unpack
   import dvp_cap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  fifo_ent_t ent,
   input  logic      empty,
   output logic      rd_en,
   output logic      out_valid,
   input  logic      out_ready,
   output logic [7:0] out_data,
   output logic      out_eof
);
   logic idx, last;

   assign out_valid = !empty;
   assign last      = !ent.two || idx;
   assign out_data  = idx ? ent.data[15:8] : ent.data[7:0];
   assign out_eof   = ent.eof && last;
   assign rd_en     = out_valid && out_ready && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      idx <= 1'b0;
      else if (out_valid && out_ready) idx <= !last;
   end
endmodule

// File: rtl/dvp_capture.sv
module dvp_capture
   import dvp_cap_pkg::*;
#(
   parameter int FIFO_AW     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = 16,
   parameter int MCLK_HALF   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_update,
   input  logic             cfg_wide,
   input  logic             cfg_byte_swap,
   input  logic             cfg_bit_rev,
   input  logic             cfg_vs_filt_en,
   input  logic [2:0]       cfg_vs_thresh,
   input  logic             cfg_eof_vsync,
   input  logic             cfg_de_mode,
   input  logic             cfg_inv_pclk,
   input  logic             cfg_inv_de,
   input  logic             cfg_inv_hsync,
   input  logic             cfg_inv_vsync,
   input  logic             cfg_stop_en,
   input  logic [LEN_W-1:0] cfg_rx_len,
   input  logic             ctl_reset,
   input  logic             fifo_reset,
   input  logic             start_set,
   input  logic             start_clr,
   output logic             running,
   input  logic             mclk_en,
   output logic             mclk_out,
   input  logic             pclk,
   input  logic             vsync,
   input  logic             hsync,
   input  logic             hen_de,
   input  logic [15:0]      pix_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_eof
);
   localparam int ENT_W = $bits(fifo_ent_t);

   if (MCLK_HALF < 1) begin : g_bad_mclk
      $error("dvp_capture: MCLK_HALF must be at least 1");
   end

   // shadow configuration
   cap_cfg_t         cfg_q;
   logic [LEN_W-1:0] rx_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         rx_len_q <= '0;
      end else if (cfg_update) begin
         cfg_q    <= '{wide: cfg_wide, byte_swap: cfg_byte_swap, bit_rev: cfg_bit_rev,
                       vs_filt_en: cfg_vs_filt_en, vs_thresh: cfg_vs_thresh,
                       eof_vsync: cfg_eof_vsync, de_mode: cfg_de_mode,
                       inv_pclk: cfg_inv_pclk, inv_de: cfg_inv_de,
                       inv_hsync: cfg_inv_hsync, inv_vsync: cfg_inv_vsync,
                       stop_en: cfg_stop_en};
         rx_len_q <= cfg_rx_len;
      end
   end

   // run control
   logic run, rd_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         run <= 1'b0;
      else if (start_clr)                 run <= 1'b0;
      else if (start_set)                 run <= 1'b1;
      else if (cfg_q.stop_en && rd_full)  run <= 1'b0;
   end
   assign running = run;

   // sensor clock
   if (MCLK_HALF == 1) begin : g_mclk_fast
      logic m;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        m <= 1'b0;
         else if (!mclk_en) m <= 1'b0;
         else               m <= ~m;
      end
      assign mclk_out = m;
   end else begin : g_mclk_div
      localparam int CW = $clog2(MCLK_HALF);
      localparam logic [CW-1:0] CMAX = CW'(MCLK_HALF - 1);
      logic [CW-1:0] cnt;
      logic          m;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
            m   <= 1'b0;
         end else if (!mclk_en) begin
            cnt <= '0;
            m   <= 1'b0;
         end else if (cnt == CMAX) begin
            cnt <= '0;
            m   <= ~m;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
      assign mclk_out = m;
   end

   // pixel clock domain
   logic pclk_eff, prst_n, wrst_n, rrst_n, run_p;

   assign pclk_eff = pclk ^ cfg_q.inv_pclk;

   dvp_rst_sync #(.STAGES(SYNC_STAGES)) u_prst (
      .clk(pclk_eff), .arst_n(rst_n & ~ctl_reset), .rst_n_o(prst_n));
   dvp_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
      .clk(pclk_eff), .arst_n(rst_n & ~fifo_reset), .rst_n_o(wrst_n));
   dvp_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
      .clk(clk), .arst_n(rst_n & ~fifo_reset), .rst_n_o(rrst_n));

   dvp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
      .clk(pclk_eff), .rst_n(prst_n), .d(run), .q(run_p));

   logic      wr_en, wfull, rd_en, rempty;
   fifo_ent_t wdata, rdata;

   dvp_pix_front #(.LEN_W(LEN_W)) u_front (
      .pclk(pclk_eff), .prst_n(prst_n), .run(run_p), .cfg(cfg_q), .rx_len(rx_len_q),
      .vsync(vsync), .hsync(hsync), .hen(hen_de), .data(pix_data),
      .wr_en(wr_en), .wdata(wdata));

   dvp_afifo #(.DW(ENT_W), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_fifo (
      .wclk(pclk_eff), .wrst_n(wrst_n), .wr_en(wr_en), .wdata(wdata), .wfull(wfull),
      .rclk(clk), .rrst_n(rrst_n), .rd_en(rd_en), .rdata(rdata), .rempty(rempty),
      .rfull(rd_full));

   dvp_unpack u_unpack (
      .clk(clk), .rst_n(rrst_n), .ent(rdata), .empty(rempty), .rd_en(rd_en),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_eof(out_eof));
endmodule

// File: rtl/dvp_capture_chk.sv
module dvp_capture_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_set,
   input logic       start_clr,
   input logic       running,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_eof,
   input logic       mclk_en,
   input logic       mclk_out,
   input logic       fifo_reset,
   input logic       stop_en_q,
   input logic       rd_full
);
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n || fifo_reset)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof)); // R13
   AST_RUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      start_set && !start_clr |=> running); // R11
   AST_RUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      start_clr |=> !running); // R11
   AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      running && stop_en_q && rd_full && !start_set |=> !running); // R10
   AST_RUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      running && !start_clr && !(stop_en_q && rd_full) |=> running); // R10
   AST_MCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mclk_en |=> !mclk_out); // R14
   AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_reset |=> !out_valid); // R12
endmodule

bind dvp_capture dvp_capture_chk chk_i (
   .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
   .running(running), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_eof(out_eof), .mclk_en(mclk_en), .mclk_out(mclk_out),
   .fifo_reset(fifo_reset), .stop_en_q(cfg_q.stop_en), .rd_full(rd_full));

// File: tb/dvp_capture_tb.sv
module dvp_capture_tb_top;
   logic clk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
   logic cfg_update = 0, cfg_wide = 0, cfg_byte_swap = 0, cfg_bit_rev = 0;
   logic cfg_vs_filt_en = 0, cfg_eof_vsync = 0, cfg_de_mode = 0, cfg_inv_pclk = 0;
   logic cfg_inv_de = 0, cfg_inv_hsync = 0, cfg_inv_vsync = 0, cfg_stop_en = 0;
   logic [2:0]  cfg_vs_thresh = 0;
   logic [15:0] cfg_rx_len = 0;
   logic ctl_reset = 0, fifo_reset = 0, start_set = 0, start_clr = 0, mclk_en = 0;
   logic vsync = 0, hsync = 0, hen_de = 0, out_ready = 0;
   logic [15:0] pix_data = 0;
   logic running, mclk_out, out_valid, out_eof;
   logic [7:0] out_data;
   logic inv_p = 0, inv_v = 0, inv_h = 0, inv_d = 0;
   int n_chk = 0, n_fail = 0;
   logic [8:0] got[$];

   always #5  clk  = ~clk;
   always #20 pclk = ~pclk;

   dvp_capture dut_i (.*);

   always @(negedge clk)
      if (rst_n && out_valid && out_ready) got.push_back({out_eof, out_data});

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sys_wait(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic commit();
      sys_wait(1); cfg_update = 1; sys_wait(1); cfg_update = 0;
      inv_p = cfg_inv_pclk; inv_v = cfg_inv_vsync; inv_h = cfg_inv_hsync; inv_d = cfg_inv_de;
   endtask

   task automatic px(input logic v, h, e, input logic [15:0] d);
      if (inv_p) @(posedge pclk); else @(negedge pclk);
      vsync = v ^ inv_v; hsync = h ^ inv_h; hen_de = e ^ inv_d; pix_data = d;
   endtask

   task automatic vpulse(input int n);
      repeat (n) px(1, 0, 0, 16'h0);
      repeat (2) px(0, 0, 0, 16'h0);
   endtask

   task automatic restart();
      sys_wait(1); start_clr = 1; sys_wait(1); start_clr = 0;
      commit();
      px(0, 0, 0, 16'h0);
      ctl_reset = 1; fifo_reset = 1; sys_wait(3); ctl_reset = 0; fifo_reset = 0;
      sys_wait(20);
      start_set = 1; sys_wait(1); start_set = 0;
      sys_wait(20);
      got.delete();
   endtask

   task automatic expect_bytes(input string tag, input logic [8:0] exp[$]);
      int bad = -1;
      sys_wait(80);
      chk(got.size() == exp.size(), {tag, " count"}, got.size(), exp.size());
      if (got.size() == exp.size()) begin
         foreach (exp[i]) if (bad < 0 && got[i] !== exp[i]) bad = i;
         chk(bad < 0, {tag, " data"}, bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp[bad]);
      end
      got.delete();
   endtask

   // R3 R8: lock on first pulse with filter off, byte-count EOF
   task automatic t_basic();
      cfg_wide = 0; cfg_vs_filt_en = 0; cfg_vs_thresh = 3'd7; cfg_eof_vsync = 0;
      cfg_rx_len = 16'd4; out_ready = 1;
      restart();
      px(0, 0, 1, 16'h00AA);          // before lock: dropped (R3)
      vpulse(1);                      // too short (R3)
      px(0, 0, 1, 16'h00BB);
      vpulse(3);
      for (int i = 1; i <= 6; i++) px(0, 0, 1, 16'(i));
      px(0, 0, 0, 16'h0);
      expect_bytes("R3_R8 basic", '{9'h001, 9'h002, 9'h003, 9'h104, 9'h005, 9'h006});
   endtask

   // R6 R7 R9: 16-bit, byte swap, EOF at frame sync
   task automatic t_wide_swap();
      cfg_wide = 1; cfg_byte_swap = 1; cfg_bit_rev = 0; cfg_eof_vsync = 1;
      restart();
      vpulse(3);
      px(0, 0, 1, 16'h1234); px(0, 0, 1, 16'hABCD); px(0, 0, 0, 16'h0);
      vpulse(3);
      expect_bytes("R6_R7_R9 swap", '{9'h012, 9'h034, 9'h0AB, 9'h1CD});
   endtask

   // R7 R6: 16-bit bit reversal, low byte first
   task automatic t_wide_rev();
      cfg_wide = 1; cfg_byte_swap = 0; cfg_bit_rev = 1; cfg_eof_vsync = 1;
      restart();
      vpulse(3);
      px(0, 0, 1, 16'h0001); px(0, 0, 1, 16'h00F0); px(0, 0, 0, 16'h0);
      vpulse(3);
      expect_bytes("R7 bitrev", '{9'h000, 9'h080, 9'h000, 9'h10F});
      cfg_bit_rev = 0; cfg_wide = 0; cfg_eof_vsync = 0;
   endtask

   // R3: filter needs thresh+1 valid pulses
   task automatic t_filter();
      cfg_vs_filt_en = 1; cfg_vs_thresh = 3'd2; cfg_rx_len = 16'd100;
      restart();
      vpulse(3); px(0, 0, 1, 16'h11);
      vpulse(1); px(0, 0, 1, 16'h12);
      vpulse(2); px(0, 0, 1, 16'h13);
      vpulse(4); px(0, 0, 1, 16'h21); px(0, 0, 1, 16'h22); px(0, 0, 0, 16'h0);
      expect_bytes("R3 filter", '{9'h021, 9'h022});
      cfg_vs_filt_en = 0;
   endtask

   // R4 R5: DE mode with inverted syncs and enable
   task automatic t_de_inv();
      cfg_de_mode = 1; cfg_inv_vsync = 1; cfg_inv_hsync = 1; cfg_inv_de = 1;
      cfg_rx_len = 16'd2;
      restart();
      vpulse(3);
      px(0, 1, 1, 16'h55); px(0, 0, 0, 16'h56);
      px(0, 0, 1, 16'h61); px(0, 0, 1, 16'h62); px(0, 0, 0, 16'h0);
      expect_bytes("R4_R5 de_mode", '{9'h061, 9'h162});
      cfg_de_mode = 0; cfg_inv_vsync = 0; cfg_inv_hsync = 0; cfg_inv_de = 0;
   endtask

   // R5 R2 R6: inverted pixel clock, then config change without strobe
   task automatic t_pclk_inv_update();
      cfg_inv_pclk = 1; cfg_rx_len = 16'd3;
      restart();
      vpulse(3);
      px(0, 0, 1, 16'h71); px(0, 0, 1, 16'h72); px(0, 0, 1, 16'h73); px(0, 0, 0, 16'h0);
      expect_bytes("R5 pclk_inv", '{9'h071, 9'h072, 9'h173});
      cfg_wide = 1; cfg_rx_len = 16'd1;     // not committed
      px(0, 0, 1, 16'h1281); px(0, 0, 0, 16'h0);
      expect_bytes("R2_R6 no_strobe", '{9'h081});
      cfg_wide = 0; cfg_inv_pclk = 0;
   endtask

   // R10 R13: auto-stop when consumer stalls
   task automatic t_autostop();
      logic [8:0] e[$];
      cfg_stop_en = 1; cfg_rx_len = 16'd1000; out_ready = 0;
      restart();
      vpulse(3);
      for (int i = 0; i < 24; i++) px(0, 0, 1, 16'(8'h30 + i));
      px(0, 0, 0, 16'h0);
      sys_wait(40);
      chk(running == 1'b0, "R10 running_fell", running, 0);
      chk(out_valid == 1'b1 && out_data == 8'h30, "R13 stall_hold", out_data, 8'h30);
      out_ready = 1;
      for (int i = 0; i < 16; i++) e.push_back(9'(8'h30 + i));
      expect_bytes("R10 kept_depth", e);
      cfg_stop_en = 0;
   endtask

   // R11: stopped unit captures nothing; R12 flush and capture reset
   task automatic t_stop_flush();
      cfg_rx_len = 16'd100;
      restart();
      chk(running == 1'b1, "R11 running_set", running, 1);
      sys_wait(1); start_clr = 1; sys_wait(1); start_clr = 0;
      sys_wait(20);
      chk(running == 1'b0, "R11 running_clr", running, 0);
      vpulse(3); px(0, 0, 1, 16'h44); px(0, 0, 0, 16'h0);
      expect_bytes("R11 stopped", '{});
      restart();
      out_ready = 0;
      vpulse(3); px(0, 0, 1, 16'h45); px(0, 0, 1, 16'h46); px(0, 0, 0, 16'h0);
      sys_wait(20);
      chk(out_valid == 1'b1, "R12 filled", out_valid, 1);
      fifo_reset = 1; ctl_reset = 1; sys_wait(1);
      chk(out_valid == 1'b0, "R12 flushed", out_valid, 0);
      sys_wait(2); fifo_reset = 0; ctl_reset = 0; sys_wait(20);
      out_ready = 1;
      px(0, 0, 1, 16'h47); px(0, 0, 0, 16'h0);
      vpulse(3); px(0, 0, 1, 16'h48); px(0, 0, 0, 16'h0);
      expect_bytes("R12 relock", '{9'h048});
   endtask

   // R14: sensor clock divider
   task automatic t_mclk();
      int rises = 0;
      logic prev;
      mclk_en = 1; sys_wait(5);
      @(negedge clk); prev = mclk_out;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (mclk_out && !prev) rises++;
         prev = mclk_out;
      end
      chk(rises == 10, "R14 mclk_rate", rises, 10);
      mclk_en = 0; sys_wait(3);
      rises = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mclk_out) rises++;
      end
      chk(rises == 0, "R14 mclk_off", rises, 0);
   endtask

   initial begin
      sys_wait(4); rst_n = 1; sys_wait(2);
      chk(running == 1'b0, "R1 running", running, 0);
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(mclk_out == 1'b0, "R1 mclk", mclk_out, 0);
      t_basic();
      t_wide_swap();
      t_wide_rev();
      t_filter();
      t_de_inv();
      t_pclk_inv_update();
      t_autostop();
      t_stop_flush();
      t_mclk();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_500_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule